// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single-byte requests into asynchronous NAND bus cycles on a shared parallel bus. A request names one of four cycle kinds (command latch, address latch, data write, data read), the chip select it targets and, for the three write-direction kinds, the byte to drive. The block lowers the chosen chip enable, sets the command and address latch enables, drives the write and read strobes through a sequence of timed phases, and for a read returns the byte it sampled on a response stream.

Phase lengths come from two 32-bit timing words, each holding four 8-bit tick counts that software derives from the flash datasheet by rounding nanosecond values up to whole clock cycles. Both words are copied into the block when a request is accepted, so a change on the timing inputs only affects later cycles. The flash ready/busy line is brought through a two-stage synchronizer and shown as the top bit of a status word.

Requests use a valid/ready handshake: a request is taken on a clock edge where both are high, and `req_ready` stays low from then until the final phase of that bus cycle has ended, and also while a read response has not yet been taken. The response stream holds `rsp_valid` and `rsp_byte` steady until `rsp_ready` is seen high.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is asserted and on leaving it, every chip enable, `flash_we_n` and `flash_re_n` are high, `flash_cle`, `flash_ale`, `flash_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: The write timing word holds ready delay in bits 31:24, write-end extension in 23:16, write cycle in 15:8 and write pulse field in 7:0. For kinds 0 to 2 the write strobe is low for (write cycle minus write pulse field) cycles, or one cycle when that difference is not positive, and the chip enable is low for ready delay + write-low + write pulse field + write-end extension cycles.
- R3: Any tick field programmed as zero acts as one cycle.
- R4: The read timing word holds access time in bits 31:24, high hold in 23:16, read pulse in 15:8 and read-end extension in 7:0. For kind 3 the read strobe is low for the larger of access time and read pulse, and the chip enable is low for ready delay + read-low + high hold + read-end extension cycles.
- R5: The returned read byte is the value of `flash_dq_in` at the clock edge that ends the access-time-th cycle of read strobe low, which is no later than the strobe's release.
- R6: `req_kind` encodes 0 command, 1 address, 2 data write, 3 data read. `flash_cle` is high throughout the chip-enable-low window of a command cycle only, `flash_ale` throughout that of an address cycle only; for kinds 0 to 2 `flash_dq_oe` is high and `flash_dq_out` equals the request byte during that window, and for kind 3 `flash_dq_oe` stays low.
- R7: Only `flash_ce_n[req_cs]` goes low for a request; at most one chip enable is ever low.
- R8: Changes on the timing inputs after a request is accepted do not alter that request's phase lengths.
- R9: `req_ready` is low from acceptance until the extension phase has ended, is high in the cycle after the chip enable returns high when no response is waiting, and is low while a read response waits.
- R10: Once `rsp_valid` is high it stays high with `rsp_byte` unchanged until an edge where `rsp_ready` is high, after which it is low.
- R11: Bit 31 of `cs_status` follows `flash_rb` two clock edges later; all other bits are zero.
- R12: The write and read strobes are never low at the same time, and the data driver is never on while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_timing | input | 32 | Write-side timing word |
| cfg_rd_timing | input | 32 | Read-side timing word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | Cycle kind: 0 command, 1 address, 2 write, 3 read |
| req_cs | input | 1 | Target chip select |
| req_byte | input | 8 | Byte to drive for kinds 0 to 2 |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Read byte taken |
| rsp_byte | output | 8 | Sampled read byte |
| flash_ce_n | output | 2 | Chip enables, active low |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_re_n | output | 1 | Read strobe, active low |
| flash_dq_out | output | 8 | Bus data driven |
| flash_dq_oe | output | 1 | Bus driver enable |
| flash_dq_in | input | 8 | Bus data sampled |
| flash_rb | input | 1 | Flash ready/busy line |
| cs_status | output | 32 | Status word, bit 31 is synchronized ready/busy |

## Verification
The bench counts strobe and chip-enable low cycles for random timing words that include zero fields, write pulse fields at or above the write cycle, and access times on both sides of the read pulse; a design that let a zero collapse a phase, wrapped the write-low subtraction or sized the read low time from one field alone gives wrong counts. During read strobe low it changes the bus byte every cycle, so sampling one edge early or late returns a different byte. It rewrites the timing inputs right after acceptance to catch a design that reads them live, and holds the response stream back to show that a pending byte blocks new requests and stays steady.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_WLOW,
    S_WHIGH,
    S_WEXT,
    S_RLOW,
    S_RHOLD,
    S_REXT
  } state_e;

endpackage

// File: rtl/nsg_sync.sv
module nsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nsg_timing.sv
module nsg_timing #(
  parameter int FIELD_W = 8,
  localparam int REG_W = 4 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [REG_W-1:0]   wr_cfg,
  input  logic [REG_W-1:0]   rd_cfg,
  output logic [FIELD_W-1:0] len_setup,
  output logic [FIELD_W-1:0] len_wlow,
  output logic [FIELD_W-1:0] len_whigh,
  output logic [FIELD_W-1:0] len_wext,
  output logic [FIELD_W-1:0] len_racc,
  output logic [FIELD_W-1:0] len_rlow,
  output logic [FIELD_W-1:0] len_rhold,
  output logic [FIELD_W-1:0] len_rext
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  logic [REG_W-1:0] wr_q, rd_q;
  logic [FIELD_W-1:0] wf [4];
  logic [FIELD_W-1:0] rf [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (load) begin
      wr_q <= wr_cfg;
      rd_q <= rd_cfg;
    end
  end

  // field 0 is the most significant slice
  for (genvar g = 0; g < 4; g++) begin : g_split
    assign wf[g] = wr_q[REG_W-1-g*FIELD_W -: FIELD_W];
    assign rf[g] = rd_q[REG_W-1-g*FIELD_W -: FIELD_W];
  end

  function automatic logic [FIELD_W-1:0] at_least_one(input logic [FIELD_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_comb begin
    len_setup = at_least_one(wf[0]);
    len_wext  = at_least_one(wf[1]);
    len_wlow  = (wf[2] > wf[3]) ? (wf[2] - wf[3]) : ONE;
    len_whigh = at_least_one(wf[3]);
    len_racc  = at_least_one(rf[0]);
    len_rhold = at_least_one(rf[1]);
    len_rlow  = (at_least_one(rf[2]) > len_racc) ? at_least_one(rf[2]) : len_racc;
    len_rext  = at_least_one(rf[3]);
  end
endmodule

// File: rtl/nsg_fsm.sv
module nsg_fsm
  import nsg_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_read,
  input  logic [FIELD_W-1:0] len_setup,
  input  logic [FIELD_W-1:0] len_wlow,
  input  logic [FIELD_W-1:0] len_whigh,
  input  logic [FIELD_W-1:0] len_wext,
  input  logic [FIELD_W-1:0] len_racc,
  input  logic [FIELD_W-1:0] len_rlow,
  input  logic [FIELD_W-1:0] len_rhold,
  input  logic [FIELD_W-1:0] len_rext,
  output state_e             state,
  output logic               capture
);
  logic [FIELD_W-1:0] cnt;
  logic [FIELD_W-1:0] cur_len;
  state_e             nxt;
  logic               done;

  always_comb begin
    cur_len = len_setup;
    nxt     = S_IDLE;
    unique case (state)
      S_IDLE:  begin cur_len = len_setup; nxt = S_SETUP; end
      S_SETUP: begin cur_len = len_setup; nxt = is_read ? S_RLOW : S_WLOW; end
      S_WLOW:  begin cur_len = len_wlow;  nxt = S_WHIGH; end
      S_WHIGH: begin cur_len = len_whigh; nxt = S_WEXT; end
      S_WEXT:  begin cur_len = len_wext;  nxt = S_IDLE; end
      S_RLOW:  begin cur_len = len_rlow;  nxt = S_RHOLD; end
      S_RHOLD: begin cur_len = len_rhold; nxt = S_REXT; end
      S_REXT:  begin cur_len = len_rext;  nxt = S_IDLE; end
      default: begin cur_len = len_setup; nxt = S_IDLE; end
    endcase
    done    = (cnt == cur_len - FIELD_W'(1));
    capture = (state == S_RLOW) && (cnt == len_racc - FIELD_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (state == S_IDLE) begin
      cnt <= '0;
      if (start) state <= S_SETUP;
    end else if (done) begin
      cnt   <= '0;
      state <= nxt;
    end else begin
      cnt <= cnt + FIELD_W'(1);
    end
  end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int FIELD_W     = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_CS      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W = 4 * FIELD_W,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  cfg_wr_timing,
  input  logic [REG_W-1:0]  cfg_rd_timing,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [DATA_W-1:0] req_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_byte,
  output logic [NUM_CS-1:0] flash_ce_n,
  output logic              flash_cle,
  output logic              flash_ale,
  output logic              flash_we_n,
  output logic              flash_re_n,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_in,
  input  logic              flash_rb,
  output logic [REG_W-1:0]  cs_status
);
  logic [FIELD_W-1:0] len_setup, len_wlow, len_whigh, len_wext;
  logic [FIELD_W-1:0] len_racc, len_rlow, len_rhold, len_rext;
  state_e             state;
  logic               capture, start, active, rb_s;
  kind_e              kind_q;
  logic [CS_W-1:0]    cs_q;
  logic [DATA_W-1:0]  byte_q;

  assign req_ready = (state == S_IDLE) && !rsp_valid;
  assign start     = req_valid && req_ready;
  assign active    = (state != S_IDLE);

  nsg_timing #(.FIELD_W(FIELD_W)) i_timing (
    .clk(clk), .rst_n(rst_n), .load(start),
    .wr_cfg(cfg_wr_timing), .rd_cfg(cfg_rd_timing),
    .len_setup(len_setup), .len_wlow(len_wlow), .len_whigh(len_whigh),
    .len_wext(len_wext), .len_racc(len_racc), .len_rlow(len_rlow),
    .len_rhold(len_rhold), .len_rext(len_rext)
  );

  nsg_fsm #(.FIELD_W(FIELD_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(kind_q == K_READ),
    .len_setup(len_setup), .len_wlow(len_wlow), .len_whigh(len_whigh),
    .len_wext(len_wext), .len_racc(len_racc), .len_rlow(len_rlow),
    .len_rhold(len_rhold), .len_rext(len_rext),
    .state(state), .capture(capture)
  );

  nsg_sync #(.STAGES(SYNC_STAGES)) i_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(flash_rb), .q(rb_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      cs_q   <= '0;
      byte_q <= '0;
    end else if (start) begin
      kind_q <= kind_e'(req_kind);
      cs_q   <= req_cs;
      byte_q <= req_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_byte  <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_byte  <= flash_dq_in;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_ce
    assign flash_ce_n[c] = !(active && (cs_q == CS_W'(c)));
  end

  assign flash_cle    = active && (kind_q == K_CMD);
  assign flash_ale    = active && (kind_q == K_ADDR);
  assign flash_we_n   = (state != S_WLOW);
  assign flash_re_n   = (state != S_RLOW);
  assign flash_dq_oe  = active && (kind_q != K_READ);
  assign flash_dq_out = byte_q;
  assign cs_status    = {rb_s, {(REG_W-1){1'b0}}};
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_byte,
  input logic [NUM_CS-1:0] flash_ce_n,
  input logic              flash_cle,
  input logic              flash_ale,
  input logic              flash_we_n,
  input logic              flash_re_n,
  input logic              flash_dq_oe
);
  // R7
  one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~flash_ce_n) <= 1);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_re_n) && !(flash_dq_oe && !flash_re_n));

  // R6
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_cle && flash_ale));

  // R9
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && (flash_ce_n != '1)));

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_ce_n == '1) && !rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  // R10
  rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);
endmodule

bind nand_strobe_gen nsg_checker #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) i_nsg_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
  .flash_ce_n(flash_ce_n), .flash_cle(flash_cle), .flash_ale(flash_ale),
  .flash_we_n(flash_we_n), .flash_re_n(flash_re_n), .flash_dq_oe(flash_dq_oe)
);

// File: tb/test_nand_strobe_gen.sv
module test_nand_strobe_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_wr_timing = '0, cfg_rd_timing = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_kind = '0;
  logic [0:0]  req_cs = '0;
  logic [7:0]  req_byte = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [7:0]  rsp_byte;
  logic [1:0]  flash_ce_n;
  logic        flash_cle, flash_ale, flash_we_n, flash_re_n, flash_dq_oe;
  logic [7:0]  flash_dq_out, flash_dq_in = '0;
  logic        flash_rb = 1'b0;
  logic [31:0] cs_status;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_strobe_gen i_nand_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr_timing(cfg_wr_timing), .cfg_rd_timing(cfg_rd_timing),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_cs(req_cs),
    .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .flash_ce_n(flash_ce_n), .flash_cle(flash_cle), .flash_ale(flash_ale),
    .flash_we_n(flash_we_n), .flash_re_n(flash_re_n), .flash_dq_out(flash_dq_out),
    .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in), .flash_rb(flash_rb),
    .cs_status(cs_status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_wlow(input logic [31:0] tw);
    int wc = int'(tw[15:8]);
    int wp = int'(tw[7:0]);
    return (wc > wp) ? wc - wp : 1;
  endfunction

  function automatic int exp_rlow(input logic [31:0] tr);
    int a = m1(int'(tr[31:24]));
    int p = m1(int'(tr[15:8]));
    return (a > p) ? a : p;
  endfunction

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One bus cycle; perturb rewrites the timing inputs after acceptance (R8)
  task automatic xfer(input logic [1:0] kind, input int cs, input logic [7:0] b,
                      input logic [31:0] tw, input logic [31:0] tr, input bit perturb);
    int ce_cnt = 0, we_cnt = 0, re_cnt = 0, bad_ce = 0, bad_latch = 0, bad_dq = 0;
    int bad_excl = 0, bad_rdy = 0, exp_ce, exp_data, guard = 0;
    logic [7:0] base = b ^ 8'h5a;
    bit is_rd = (kind == 2'd3);
    cfg_wr_timing = tw;
    cfg_rd_timing = tr;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_cs = cs[0]; req_byte = b;
    flash_dq_in = base;
    @(negedge clk);
    req_valid = 1'b0;
    if (perturb) begin
      cfg_wr_timing = $urandom;
      cfg_rd_timing = $urandom;
    end
    while (flash_ce_n != 2'b11 && guard < 2000) begin
      guard++;
      if (flash_ce_n[cs] == 1'b0) ce_cnt++;
      if (flash_ce_n[1-cs] == 1'b0) bad_ce++;
      if (flash_cle != (kind == 2'd0) || flash_ale != (kind == 2'd1)) bad_latch++;
      if (flash_dq_oe != !is_rd || (!is_rd && flash_dq_out != b)) bad_dq++;
      if ((!flash_we_n && !flash_re_n) || (flash_dq_oe && !flash_re_n)) bad_excl++;
      if (req_ready) bad_rdy++;
      if (!flash_we_n) we_cnt++;
      if (!flash_re_n) begin
        re_cnt++;
        flash_dq_in = base + 8'(re_cnt);
      end
      @(negedge clk);
    end
    if (is_rd) begin
      exp_ce = m1(int'(tw[31:24])) + exp_rlow(tr) + m1(int'(tr[23:16])) + m1(int'(tr[7:0]));
      chk(re_cnt == exp_rlow(tr), "R4 read strobe low cycles", re_cnt, exp_rlow(tr));
      chk(ce_cnt == exp_ce, "R4 read chip enable low cycles", ce_cnt, exp_ce);
      chk(we_cnt == 0, "R12 no write strobe in read", we_cnt, 0);
      exp_data = int'(8'(base + 8'(m1(int'(tr[31:24])))));
      chk(rsp_valid == 1'b1, "R10 response valid after read", int'(rsp_valid), 1);
      chk(int'(rsp_byte) == exp_data, "R5 sampled byte at access edge", int'(rsp_byte), exp_data);
      chk(req_ready == 1'b0, "R9 ready low while response waits", int'(req_ready), 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1 && int'(rsp_byte) == exp_data, "R10 response held", int'(rsp_byte), exp_data);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid == 1'b0, "R10 response dropped after take", int'(rsp_valid), 0);
      chk(req_ready == 1'b1, "R9 ready after response taken", int'(req_ready), 1);
    end else begin
      exp_ce = m1(int'(tw[31:24])) + exp_wlow(tw) + m1(int'(tw[7:0])) + m1(int'(tw[23:16]));
      chk(we_cnt == exp_wlow(tw), "R2 write strobe low cycles", we_cnt, exp_wlow(tw));
      chk(ce_cnt == exp_ce, "R2 write chip enable low cycles", ce_cnt, exp_ce);
      chk(re_cnt == 0, "R12 no read strobe in write", re_cnt, 0);
      chk(req_ready == 1'b1, "R9 ready after extension", int'(req_ready), 1);
    end
    chk(bad_ce == 0, "R7 other chip enable low", bad_ce, 0);
    chk(bad_latch == 0, "R6 latch enables", bad_latch, 0);
    chk(bad_dq == 0, "R6 data driver", bad_dq, 0);
    chk(bad_excl == 0, "R12 strobe exclusion", bad_excl, 0);
    chk(bad_rdy == 0, "R9 ready low during cycle", bad_rdy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1
    chk(flash_ce_n == 2'b11 && flash_we_n && flash_re_n, "R1 strobes idle in reset", int'(flash_ce_n), 3);
    chk(!flash_cle && !flash_ale && !flash_dq_oe && !rsp_valid, "R1 enables low in reset",
        int'({flash_cle, flash_ale, flash_dq_oe, rsp_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(cs_status == 32'h0, "R11 status zero after reset", int'(cs_status), 0);

    // R3: all fields zero
    xfer(2'd0, 0, 8'h70, 32'h0, 32'h0, 1'b0);
    xfer(2'd3, 1, 8'h00, 32'h0, 32'h0, 1'b0);
    // R2: write pulse field not below write cycle
    xfer(2'd2, 1, 8'hc3, 32'h02_01_03_05, 32'h0, 1'b0);
    xfer(2'd1, 0, 8'h11, 32'h01_02_06_02, 32'h0, 1'b0);
    // R4/R5: access time above and below read pulse
    xfer(2'd3, 0, 8'h20, 32'h01_00_00_00, 32'h05_02_02_01, 1'b0);
    xfer(2'd3, 1, 8'h40, 32'h03_00_00_00, 32'h02_01_06_03, 1'b0);
    // R8: timing inputs rewritten after acceptance
    xfer(2'd2, 0, 8'h9e, 32'h02_03_07_02, 32'h0, 1'b1);
    xfer(2'd3, 0, 8'h81, 32'h02_00_00_00, 32'h03_02_04_02, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] tw, tr;
      tw = {8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 8), 8'($urandom % 6)};
      tr = {8'($urandom % 7), 8'($urandom % 5), 8'($urandom % 7), 8'($urandom % 5)};
      xfer(2'($urandom), int'($urandom % 2), 8'($urandom), tw, tr, i[0]);
    end

    // R11: ready/busy through two flops
    @(negedge clk);
    flash_rb = 1'b1;
    @(negedge clk);
    chk(cs_status[31] == 1'b0, "R11 status not yet updated", int'(cs_status[31]), 0);
    @(negedge clk);
    chk(cs_status == 32'h8000_0000, "R11 status shows ready", int'(cs_status[31]), 1);
    flash_rb = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_status == 32'h0, "R11 status shows busy", int'(cs_status[31]), 0);
    report();
  end
endmodule